// File: doc/BRIEF.md
# Power-Pulsing Clock and Readout Controller

This controller keeps a front-end chip powered only during short acquisition bursts, with long idle gaps between them; the duty cycle is about half a percent. It takes three power-on requests, one each for the analog, threshold-DAC and digital domains. It brings each request into the local clock domain and drives an enable for that domain. For the analog and DAC domains it also drives a ready flag. Each ready flag rises once that domain's wake-up time has elapsed. That time is counted in cycles of the free-running clock.

The bias current of the receiver that brings in the clock follows the digital domain. The controller also gates two clocks from the incoming clock. The acquisition and conversion clock runs while the shared digital power-on is active and the chip is not in readout mode. The readout clock runs between a start token and the chip's own end of readout. The end-of-readout pulse goes to the next chip in a daisy chain, where it serves as that chip's start token. Both clock gates change state only while the incoming clock is low, so the gated clocks never carry runt pulses.

Top module: `pwr_pulse_ctrl`

## Requirements
- R1: While rst_ni is low, every output is 0 whatever the power-on inputs are.
- R2: Each domain enable (ana_en_o, dac_en_o, dig_en_o) goes to the value of its power-on input on the second rising clock edge after that input changes. lvds_bias_en_o always equals dig_en_o.
- R3: ana_rdy_o rises exactly ANA_WAKE_CYC cycles after ana_en_o rises. It is 0 whenever ana_en_o is 0.
- R4: dac_rdy_o rises exactly DAC_WAKE_CYC cycles after dac_en_o rises. It is 0 whenever dac_en_o is 0.
- R5: daq_clk_o follows clk_i while dig_en_o is 1 and ro_mode_i is 0, and otherwise stays low. Its gate opens or closes only while clk_i is low, so the first and last pulses are full high phases, one cycle after the request changes.
- R6: A start_ro_i sampled high on a rising edge starts a readout, provided dig_en_o is 1 and no readout is in progress. ro_clk_o then carries full pulses from the next high phase onward. A start_ro_i seen while dig_en_o is 0 has no effect.
- R7: A ro_done_i sampled high during a readout ends it. end_ro_o is high for exactly one cycle after that edge, and ro_clk_o stops one cycle later.
- R8: A start_ro_i seen while a readout is in progress is ignored. That readout produces exactly one end_ro_o pulse, and no new readout follows it.
- R9: When dig_en_o falls, any readout in progress is dropped without an end_ro_o pulse, and ro_clk_o stops. With all power-on inputs at 0, every enable and ready flag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running incoming clock; also counts the wake-up times |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pwr_ana_i | input | 1 | Analog domain power-on request (asynchronous) |
| pwr_dac_i | input | 1 | DAC domain power-on request (asynchronous) |
| pwr_dig_i | input | 1 | Digital power-on request shared by all chips (asynchronous) |
| ro_mode_i | input | 1 | 1 selects readout mode and blocks the acquisition clock |
| start_ro_i | input | 1 | Start-of-readout token from the previous chip |
| ro_done_i | input | 1 | Local readout finished |
| ana_en_o | output | 1 | Analog domain enable |
| dac_en_o | output | 1 | DAC domain enable |
| dig_en_o | output | 1 | Digital domain enable |
| lvds_bias_en_o | output | 1 | Clock receiver bias enable |
| ana_rdy_o | output | 1 | Analog wake-up time elapsed |
| dac_rdy_o | output | 1 | DAC wake-up time elapsed |
| daq_clk_o | output | 1 | Gated acquisition and conversion clock |
| ro_clk_o | output | 1 | Gated readout clock |
| end_ro_o | output | 1 | One-cycle end-of-readout token to the next chip |

## Verification
The checks assume that start_ro_i and ro_done_i are synchronous to clk_i and are held for one cycle. They also assume that ro_done_i is raised only during a readout, and that reset is released away from a falling clock edge. The bench drives every input 1 ns after a rising edge and takes all samples 2 ns after it, during the high phase. At that point a gated clock that is enabled must read 1. Bench and wake-up parameters are kept short so that every ready delay can be counted cycle by cycle.

// File: rtl/pwr_pulse_pkg.sv
package pwr_pulse_pkg;
  localparam int unsigned SYNC_STAGES = 2;

  typedef struct packed {
    logic ana;
    logic dac;
    logic dig;
  } pwr_dom_t;

  localparam int unsigned DOM_W = $bits(pwr_dom_t);
endpackage

// File: rtl/pwr_sync.sv
module pwr_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     stg_q[s] <= '0;
      else if (s == 0) stg_q[s] <= d_i;
      else             stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/pwr_wake_timer.sv
module pwr_wake_timer #(
  parameter int unsigned WAKE_CYC = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic rdy_o
);
  localparam int unsigned CW = $clog2(WAKE_CYC + 1);
  localparam logic [CW-1:0] LIMIT = CW'(WAKE_CYC);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (!en_i)         cnt_q <= '0;
    else if (cnt_q < LIMIT) cnt_q <= cnt_q + 1'b1;
  end

  assign rdy_o = en_i && (cnt_q == LIMIT);

  AST_RDY_AFTER_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rdy_o) |-> $past(en_i)) else $error("ready without prior enable"); // R3
  AST_RDY_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdy_o && en_i |=> rdy_o || !en_i) else $error("ready dropped while enabled"); // R4
endmodule

// File: rtl/pwr_clk_gate.sv
module pwr_clk_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic clk_o
);
  logic gate_q;

  // Gate only moves on the falling edge: no partial high phase.
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gate_q <= 1'b0;
    else         gate_q <= en_i;
  end

  assign clk_o = clk_i & gate_q;

  always @(gate_q) begin
    if (rst_ni) AST_GATE_CLK_LOW: assert (!clk_i) else $error("gate moved while clock high"); // R5
  end
endmodule

// File: rtl/pwr_ro_token.sv
module pwr_ro_token (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic dig_en_i,
  input  logic start_i,
  input  logic done_i,
  output logic busy_o,
  output logic end_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      end_o  <= 1'b0;
    end else begin
      end_o <= 1'b0;
      if (!dig_en_i) begin
        busy_o <= 1'b0;
      end else if (busy_o) begin
        if (done_i) begin
          busy_o <= 1'b0;
          end_o  <= 1'b1;
        end
      end else if (start_i) begin
        busy_o <= 1'b1;
      end
    end
  end

  AST_END_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    end_o |=> !end_o) else $error("end token longer than one cycle"); // R7
  AST_END_FROM_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    end_o |-> $past(busy_o) && !busy_o) else $error("end token without readout"); // R8
  AST_UNPOWERED_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dig_en_i |=> !busy_o && !end_o) else $error("readout alive without power"); // R9
endmodule

// File: rtl/pwr_pulse_ctrl.sv
module pwr_pulse_ctrl
  import pwr_pulse_pkg::*;
#(
  parameter int unsigned ANA_WAKE_CYC = 1000,
  parameter int unsigned DAC_WAKE_CYC = 3125
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwr_ana_i,
  input  logic pwr_dac_i,
  input  logic pwr_dig_i,
  input  logic ro_mode_i,
  input  logic start_ro_i,
  input  logic ro_done_i,
  output logic ana_en_o,
  output logic dac_en_o,
  output logic dig_en_o,
  output logic lvds_bias_en_o,
  output logic ana_rdy_o,
  output logic dac_rdy_o,
  output logic daq_clk_o,
  output logic ro_clk_o,
  output logic end_ro_o
);
  pwr_dom_t req_raw, req_s;
  logic     ro_busy;
  logic     daq_req;

  assign req_raw = '{ana: pwr_ana_i, dac: pwr_dac_i, dig: pwr_dig_i};

  pwr_sync #(.W(DOM_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (req_raw),
    .q_o   (req_s)
  );

  assign ana_en_o       = req_s.ana;
  assign dac_en_o       = req_s.dac;
  assign dig_en_o       = req_s.dig;
  assign lvds_bias_en_o = req_s.dig;

  pwr_wake_timer #(.WAKE_CYC(ANA_WAKE_CYC)) u_ana_wake (
    .clk_i (clk_i), .rst_ni(rst_ni), .en_i(req_s.ana), .rdy_o(ana_rdy_o)
  );

  pwr_wake_timer #(.WAKE_CYC(DAC_WAKE_CYC)) u_dac_wake (
    .clk_i (clk_i), .rst_ni(rst_ni), .en_i(req_s.dac), .rdy_o(dac_rdy_o)
  );

  assign daq_req = req_s.dig & ~ro_mode_i;

  pwr_clk_gate u_daq_gate (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(daq_req), .clk_o(daq_clk_o)
  );

  pwr_ro_token u_ro (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .dig_en_i(req_s.dig),
    .start_i (start_ro_i),
    .done_i  (ro_done_i),
    .busy_o  (ro_busy),
    .end_o   (end_ro_o)
  );

  pwr_clk_gate u_ro_gate (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(ro_busy), .clk_o(ro_clk_o)
  );

  AST_ANA_RDY_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ana_rdy_o |-> ana_en_o) else $error("analog ready while off"); // R3
  AST_DAC_RDY_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dac_rdy_o |-> dac_en_o) else $error("dac ready while off"); // R4
  AST_EN_TRACKS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dig_en_o) |-> $past(pwr_dig_i)) else $error("digital enable without request"); // R2
endmodule

// File: tb/tb_pwr_pulse_ctrl.sv
module tb_pwr_pulse_ctrl;
  localparam int ANA_W = 8;
  localparam int DAC_W = 20;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic pwr_ana = 0, pwr_dac = 0, pwr_dig = 0, ro_mode = 0, start_ro = 0, ro_done = 0;
  logic ana_en, dac_en, dig_en, bias_en, ana_rdy, dac_rdy, daq_clk, ro_clk, end_ro;

  always #4 clk = ~clk;

  pwr_pulse_ctrl #(.ANA_WAKE_CYC(ANA_W), .DAC_WAKE_CYC(DAC_W)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .pwr_ana_i(pwr_ana), .pwr_dac_i(pwr_dac),
    .pwr_dig_i(pwr_dig), .ro_mode_i(ro_mode), .start_ro_i(start_ro), .ro_done_i(ro_done),
    .ana_en_o(ana_en), .dac_en_o(dac_en), .dig_en_o(dig_en), .lvds_bias_en_o(bias_en),
    .ana_rdy_o(ana_rdy), .dac_rdy_o(dac_rdy), .daq_clk_o(daq_clk), .ro_clk_o(ro_clk),
    .end_ro_o(end_ro)
  );

  typedef enum int {S_ANA_EN, S_DAC_EN, S_DIG_EN, S_BIAS, S_ANA_RDY, S_DAC_RDY,
                    S_DAQ_CLK, S_RO_CLK, S_END_RO} sig_e;
  typedef struct {string req; sig_e sig; logic exp;} item_t;

  item_t exp_q[$];
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  function automatic logic pick(sig_e s);
    case (s)
      S_ANA_EN:  return ana_en;
      S_DAC_EN:  return dac_en;
      S_DIG_EN:  return dig_en;
      S_BIAS:    return bias_en;
      S_ANA_RDY: return ana_rdy;
      S_DAC_RDY: return dac_rdy;
      S_DAQ_CLK: return daq_clk;
      S_RO_CLK:  return ro_clk;
      default:   return end_ro;
    endcase
  endfunction

  task automatic expect_v(string r, sig_e s, logic v);
    item_t it;
    it.req = r; it.sig = s; it.exp = v;
    exp_q.push_back(it);
  endtask

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  // Monitor: samples 2 ns after each rising edge, during the high phase.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      while (exp_q.size() > 0) begin
        item_t it;
        logic act;
        it  = exp_q.pop_front();
        act = pick(it.sig);
        n_cmp++;
        if (act !== it.exp) begin
          n_bad++;
          $display("FAIL %s %s actual=%b expected=%b", it.req, it.sig.name(), act, it.exp);
        end
      end
    end
  end

  initial begin
    #100000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    // R1: reset dominates power requests
    pwr_ana = 1; pwr_dac = 1; pwr_dig = 1;
    step(4);
    expect_v("R1", S_ANA_EN, 0); expect_v("R1", S_DAC_EN, 0); expect_v("R1", S_DIG_EN, 0);
    expect_v("R1", S_BIAS, 0); expect_v("R1", S_ANA_RDY, 0); expect_v("R1", S_DAC_RDY, 0);
    expect_v("R1", S_DAQ_CLK, 0); expect_v("R1", S_RO_CLK, 0); expect_v("R1", S_END_RO, 0);
    step();
    pwr_ana = 0; pwr_dac = 0; pwr_dig = 0;
    step();
    rst_ni = 1;
    step(3);

    // R2 / R3: analog domain
    pwr_ana = 1;
    step(); expect_v("R2", S_ANA_EN, 0);
    step(); expect_v("R2", S_ANA_EN, 1); expect_v("R3", S_ANA_RDY, 0);
    step(ANA_W - 1); expect_v("R3", S_ANA_RDY, 0);
    step(); expect_v("R3", S_ANA_RDY, 1);
    pwr_ana = 0;
    step(); expect_v("R3", S_ANA_RDY, 1);
    step(); expect_v("R2", S_ANA_EN, 0); expect_v("R3", S_ANA_RDY, 0);

    // R4: DAC domain
    pwr_dac = 1;
    step(2); expect_v("R4", S_DAC_EN, 1);
    step(DAC_W - 1); expect_v("R4", S_DAC_RDY, 0);
    step(); expect_v("R4", S_DAC_RDY, 1);

    // R2 / R5: digital domain and acquisition clock
    ro_mode = 0; pwr_dig = 1;
    step(); expect_v("R2", S_DIG_EN, 0); expect_v("R2", S_BIAS, 0);
    step(); expect_v("R2", S_DIG_EN, 1); expect_v("R2", S_BIAS, 1); expect_v("R5", S_DAQ_CLK, 0);
    step(); expect_v("R5", S_DAQ_CLK, 1);
    step(3); expect_v("R5", S_DAQ_CLK, 1);
    ro_mode = 1;
    expect_v("R5", S_DAQ_CLK, 1);
    step(); expect_v("R5", S_DAQ_CLK, 0);

    // R6: readout start
    start_ro = 1;
    step(); start_ro = 0;
    expect_v("R6", S_RO_CLK, 0); expect_v("R6", S_END_RO, 0);
    step(); expect_v("R6", S_RO_CLK, 1);
    step(3); expect_v("R6", S_RO_CLK, 1);

    // R8: start during readout ignored
    start_ro = 1;
    step(); start_ro = 0;
    expect_v("R8", S_RO_CLK, 1); expect_v("R8", S_END_RO, 0);
    step();

    // R7: end of readout
    ro_done = 1;
    step(); ro_done = 0;
    expect_v("R7", S_END_RO, 1); expect_v("R7", S_RO_CLK, 1);
    step(); expect_v("R7", S_END_RO, 0); expect_v("R7", S_RO_CLK, 0);
    step(2); expect_v("R8", S_RO_CLK, 0); expect_v("R8", S_END_RO, 0);

    // R9: power drop during readout
    start_ro = 1;
    step(); start_ro = 0;
    step(); expect_v("R6", S_RO_CLK, 1);
    pwr_dig = 0; pwr_dac = 0; pwr_ana = 0;
    step(); expect_v("R9", S_DIG_EN, 1);
    step(); expect_v("R9", S_DIG_EN, 0); expect_v("R9", S_BIAS, 0);
    expect_v("R9", S_DAC_EN, 0); expect_v("R9", S_DAC_RDY, 0); expect_v("R9", S_ANA_EN, 0);
    step(2); expect_v("R9", S_RO_CLK, 0); expect_v("R9", S_END_RO, 0);
    step(); expect_v("R9", S_END_RO, 0); expect_v("R9", S_ANA_RDY, 0);

    // R6: start while unpowered has no effect
    start_ro = 1;
    step(); start_ro = 0;
    step(2); expect_v("R6", S_RO_CLK, 0);
    pwr_dig = 1;
    step(4); expect_v("R6", S_RO_CLK, 0); expect_v("R6", S_END_RO, 0);
    step(2);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule